// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This unit adds or subtracts two packed vectors lane by lane and clamps every lane to the range its type can hold. It serves a 128-bit vector datapath. The lane size can be 8, 16, 32 or 64 bits, and each lane size can be treated as signed or unsigned. An opcode field picks addition or subtraction, and a separate bit picks the signedness. The operation runs on either the full vector or only its low half. In half mode, the upper half of the result is written as zero.

A sticky saturation flag records that some lane of some earlier operation was clamped. The flag only collects saturation events. It returns to zero only on reset or through an explicit clear input. The result and the flag are registered on the same edge, one cycle after the operation is presented with `in_valid`. An opcode the unit does not recognise is reported on `illegal`, and it changes neither the result nor the flag.

Top module: `vsat_addsub`

## Requirements
- R1: A lane whose exact sum or difference fits its type returns that exact value. Lane size is encoded on `lane_sz` as 0=8, 1=16, 2=32 and 3=64 bits, and lane i occupies bits [i*W +: W].
- R2: With `uns`=1, a lane whose exact result is above 2^W-1 returns all ones, and one whose exact result is below 0 returns 0.
- R3: With `uns`=0, a lane that overflows returns the most negative value if its first operand is negative, and the most positive value otherwise.
- R4: A legal operation in which at least one active lane saturates sets `sat_flag` to 1.
- R5: A legal operation with no saturating active lane leaves `sat_flag` unchanged.
- R6: `flag_clr` clears `sat_flag` on the next edge, except when an operation that saturates is accepted in the same cycle; in that case the flag is set.
- R7: With `wide`=0, bits [127:64] of the result are zero, and lanes in those bits do not affect `sat_flag`. With `wide`=1, all 128 bits are computed.
- R8: `op_code` 0x01 selects saturating add and 0x05 selects saturating subtract. `uns`=1 selects unsigned and `uns`=0 selects signed.
- R9: Any other `op_code` raises `illegal` with `out_valid` and leaves both `result` and the set state of `sat_flag` unchanged.
- R10: `out_valid` is asserted exactly one cycle after each `in_valid`, and `result` is updated on that same edge.
- R11: After reset, `result`, `sat_flag`, `out_valid` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_code | input | 6 | Operation code: 0x01 add, 0x05 subtract |
| uns | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| lane_sz | input | 2 | Lane size: 0=8, 1=16, 2=32, 3=64 bits |
| wide | input | 1 | 1 = full 128-bit vector, 0 = low 64 bits only |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| flag_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 128 | Registered saturated result |
| illegal | output | 1 | The previous cycle's operation had an unknown opcode |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
Every output of this block is due on the first rising edge after the cycle in which `in_valid` is high. This covers `result`, `sat_flag`, `out_valid` and `illegal`. The bench drives each operation at a falling edge and drops `in_valid` at the next falling edge. It then compares all four outputs at that same falling edge, which is half a period after the single register stage has loaded. A further idle cycle confirms that `out_valid` returns low. Between operations, a bench-side model of the sticky flag and of the held result carries the expected state forward.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
   localparam int unsigned NUM_SIZES = 4;
   typedef enum logic [1:0] {
      LSZ_8  = 2'd0,
      LSZ_16 = 2'd1,
      LSZ_32 = 2'd2,
      LSZ_64 = 2'd3
   } lane_size_e;

   function automatic int unsigned lane_width(input int unsigned k);
      return 8 << k;
   endfunction
endpackage

// File: rtl/vsat_decode.sv
module vsat_decode #(
   parameter int unsigned OPC_W   = 6,
   parameter int unsigned OPC_ADD = 1,
   parameter int unsigned OPC_SUB = 5
) (
   input  logic [OPC_W-1:0] op_code,
   output logic             legal,
   output logic             is_sub
);
   if (OPC_ADD == OPC_SUB) begin : g_bad_codes
      $error("add and subtract codes must differ");
   end
   if (OPC_ADD >= (1 << OPC_W) || OPC_SUB >= (1 << OPC_W)) begin : g_bad_width
      $error("opcode values do not fit the opcode field");
   end

   localparam logic [OPC_W-1:0] CODE_ADD = OPC_W'(OPC_ADD);
   localparam logic [OPC_W-1:0] CODE_SUB = OPC_W'(OPC_SUB);

   always_comb begin
      legal  = (op_code == CODE_ADD) || (op_code == CODE_SUB);
      is_sub = (op_code == CODE_SUB);
   end

   always_comb begin
      if (is_sub) AST_SUB_IMPLIES_LEGAL: assert (legal); // R8
   end
endmodule

// File: rtl/vsat_lane.sv
module vsat_lane #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         uns,
   output logic [W-1:0] res,
   output logic         sat
);
   if (W < 2) begin : g_bad_w
      $error("lane width too small");
   end

   localparam logic [W-1:0] U_MAX = '1;
   localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

   logic [W:0]   ext_sum;
   logic [W-1:0] wrap;
   logic         u_ovf;
   logic         s_ovf;

   always_comb begin
      ext_sum = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      wrap    = ext_sum[W-1:0];
      u_ovf   = ext_sum[W];
      if (sub) s_ovf = (a[W-1] != b[W-1]) && (wrap[W-1] != a[W-1]);
      else     s_ovf = (a[W-1] == b[W-1]) && (wrap[W-1] != a[W-1]);
      sat = uns ? u_ovf : s_ovf;
      if (!sat)     res = wrap;
      else if (uns) res = sub ? '0 : U_MAX;
      else          res = a[W-1] ? S_MIN : S_MAX;
   end

   always_comb begin
      if (sat && uns && !sub) AST_UNS_ADD_CLAMP: assert (res == U_MAX); // R2
      if (sat && uns && sub)  AST_UNS_SUB_CLAMP: assert (res == '0); // R2
      if (sat && !uns)        AST_SGN_CLAMP: assert (res[W-1] == a[W-1]); // R3
   end
endmodule

// File: rtl/vsat_size_slice.sv
module vsat_size_slice #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned LANE_W = 8
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic             sub,
   input  logic             uns,
   input  logic             wide,
   output logic [VEC_W-1:0] res,
   output logic             sat_any
);
   localparam int unsigned NL     = VEC_W / LANE_W;
   localparam int unsigned HALF_W = VEC_W / 2;

   if (VEC_W % LANE_W != 0) begin : g_bad_div
      $error("vector width must be a multiple of lane width");
   end

   logic [NL-1:0] sat_v;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      localparam bit LOW_HALF = ((i + 1) * LANE_W) <= HALF_W;
      logic [LANE_W-1:0] l_res;
      logic              l_sat;
      logic              act;

      vsat_lane #(.W(LANE_W)) u_lane (
         .a   (a[i*LANE_W +: LANE_W]),
         .b   (b[i*LANE_W +: LANE_W]),
         .sub (sub),
         .uns (uns),
         .res (l_res),
         .sat (l_sat)
      );

      assign act                     = LOW_HALF || wide;
      assign res[i*LANE_W +: LANE_W] = act ? l_res : '0;
      assign sat_v[i]                = act & l_sat;
   end

   assign sat_any = |sat_v;
endmodule

// File: rtl/vsat_addsub.sv
module vsat_addsub #(
   parameter int unsigned VEC_W   = 128,
   parameter int unsigned OPC_W   = 6,
   parameter int unsigned OPC_ADD = 1,
   parameter int unsigned OPC_SUB = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [OPC_W-1:0] op_code,
   input  logic             uns,
   input  logic [1:0]       lane_sz,
   input  logic             wide,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             flag_clr,
   output logic             out_valid,
   output logic [VEC_W-1:0] result,
   output logic             illegal,
   output logic             sat_flag
);
   import vsat_pkg::*;

   localparam int unsigned HALF_W = VEC_W / 2;

   if (VEC_W % 128 != 0) begin : g_bad_vec
      $error("vector width must be a multiple of 128");
   end

   logic                 legal;
   logic                 is_sub;
   logic [VEC_W-1:0]     res_by_sz [NUM_SIZES];
   logic [NUM_SIZES-1:0] sat_by_sz;
   logic [VEC_W-1:0]     res_sel;
   logic                 sat_sel;
   logic                 accept;

   vsat_decode #(.OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_SUB(OPC_SUB)) u_dec (
      .op_code (op_code),
      .legal   (legal),
      .is_sub  (is_sub)
   );

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      vsat_size_slice #(.VEC_W(VEC_W), .LANE_W(lane_width(k))) u_slice (
         .a       (src_a),
         .b       (src_b),
         .sub     (is_sub),
         .uns     (uns),
         .wide    (wide),
         .res     (res_by_sz[k]),
         .sat_any (sat_by_sz[k])
      );
   end

   always_comb begin
      res_sel = res_by_sz[lane_sz];
      sat_sel = sat_by_sz[lane_sz];
      accept  = in_valid && legal;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         illegal   <= in_valid && !legal;
         if (accept) result <= res_sel;
         if (accept && sat_sel) sat_flag <= 1'b1;
         else if (flag_clr)     sat_flag <= 1'b0;
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R10
   AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !wide) |=> (result[VEC_W-1:HALF_W] == '0)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !flag_clr) |=> sat_flag); // R5
   AST_SAT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sat_sel && flag_clr) |=> sat_flag); // R6
   AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !legal) |=> ($stable(result) && illegal)); // R9
endmodule

// File: tb/vsat_addsub_tb_top.sv
module vsat_addsub_tb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [5:0]   op_code;
   logic         uns;
   logic [1:0]   lane_sz;
   logic         wide;
   logic [127:0] src_a;
   logic [127:0] src_b;
   logic         flag_clr;
   logic         out_valid;
   logic [127:0] result;
   logic         illegal;
   logic         sat_flag;

   int           n_chk  = 0;
   int           n_fail = 0;
   logic [127:0] exp_res = '0;
   logic         exp_flag = 1'b0;
   bit           finished = 1'b0;

   always #5 clk = ~clk;

   vsat_addsub dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .uns(uns), .lane_sz(lane_sz), .wide(wide), .src_a(src_a), .src_b(src_b),
      .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
      .illegal(illegal), .sat_flag(sat_flag)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [63:0] lmask(input int w);
      return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
   endfunction

   function automatic logic [63:0] pick(input int w, input int idx);
      logic [63:0] m;
      m = lmask(w);
      case (idx % 8)
         0: return 64'd0;
         1: return 64'd1;
         2: return m >> 1;
         3: return (m >> 1) + 64'd1;
         4: return m;
         5: return 64'h5555_5555_5555_5555 & m;
         6: return 64'd2;
         default: return m - 64'd1;
      endcase
   endfunction

   function automatic logic signed [66:0] extend(input logic [63:0] v, input int w, input bit u);
      logic signed [63:0] t;
      if (u) return {3'b000, v};
      t = $signed(v << (64 - w)) >>> (64 - w);
      return {{3{t[63]}}, t};
   endfunction

   function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input int w, input bit u, input bit sb,
                                         output bit sat);
      logic signed [66:0] ea, eb, ex, hi, lo;
      logic [63:0] m;
      m  = lmask(w);
      ea = extend(a & m, w, u);
      eb = extend(b & m, w, u);
      ex = sb ? (ea - eb) : (ea + eb);
      hi = u ? {3'b000, m} : {3'b000, m >> 1};
      lo = u ? 67'sd0 : (-hi - 67'sd1);
      sat = 1'b0;
      if (ex > hi) begin sat = 1'b1; ex = hi; end
      else if (ex < lo) begin sat = 1'b1; ex = lo; end
      return ex[63:0] & m;
   endfunction

   task automatic run_op(input logic [5:0] opc, input bit u, input int sz, input bit wd,
                         input logic [127:0] a, input logic [127:0] b, input bit clr);
      int w, nl;
      bit any_sat, ls, legal;
      logic [127:0] calc;
      logic [63:0] r;
      w = 8 << sz;
      nl = 128 / w;
      calc = '0;
      any_sat = 1'b0;
      for (int i = 0; i < nl; i++) begin
         if (wd || ((i + 1) * w) <= 64) begin
            r = model(64'(a >> (i * w)), 64'(b >> (i * w)), w, u, (opc == 6'h05), ls);
            calc = calc | (128'(r) << (i * w));
            any_sat = any_sat | ls;
         end
      end
      legal = (opc == 6'h01) || (opc == 6'h05);
      if (legal) exp_res = calc;
      if (legal && any_sat) exp_flag = 1'b1;
      else if (clr) exp_flag = 1'b0;

      @(negedge clk);
      in_valid = 1'b1; op_code = opc; uns = u; lane_sz = 2'(sz); wide = wd;
      src_a = a; src_b = b; flag_clr = clr;
      @(negedge clk);
      in_valid = 1'b0; flag_clr = 1'b0;
      check(out_valid == 1'b1, "R10 out_valid after op", 128'(out_valid), 128'd1);
      check(illegal == !legal, "R9 illegal indication", 128'(illegal), 128'(!legal));
      if (!legal)
         check(result == exp_res, "R9 result held", result, exp_res);
      else if (any_sat)
         check(result == exp_res, u ? "R2 R8 unsigned clamp" : "R3 R8 signed clamp", result, exp_res);
      else
         check(result == exp_res, "R1 R8 exact result", result, exp_res);
      if (legal && !wd)
         check(result[127:64] == '0, "R7 upper half zero", result, exp_res);
      check(sat_flag == exp_flag,
            (legal && any_sat) ? "R4 flag set" : (clr ? "R6 flag clear" : "R5 flag kept"),
            128'(sat_flag), 128'(exp_flag));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] a, b;
      int w;
      rst_n = 1'b0; in_valid = 1'b0; op_code = '0; uns = 1'b0; lane_sz = '0;
      wide = 1'b0; src_a = '0; src_b = '0; flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(result == '0, "R11 reset result", result, '0);
      check(sat_flag == 1'b0, "R11 reset flag", 128'(sat_flag), '0);
      check(out_valid == 1'b0, "R11 reset out_valid", 128'(out_valid), '0);
      check(illegal == 1'b0, "R11 reset illegal", 128'(illegal), '0);

      for (int sz = 0; sz < 4; sz++)
         for (int u = 0; u < 2; u++)
            for (int op = 0; op < 2; op++)
               for (int wd = 0; wd < 2; wd++)
                  for (int s1 = 0; s1 < 4; s1++)
                     for (int s2 = 0; s2 < 4; s2++) begin
                        w = 8 << sz;
                        a = '0; b = '0;
                        for (int i = 0; i < 128 / w; i++) begin
                           a = a | (128'(pick(w, i + s1)) << (i * w));
                           b = b | (128'(pick(w, 3 * i + s2 + 2 * s1)) << (i * w));
                        end
                        run_op(op ? 6'h05 : 6'h01, u[0], sz, wd[0], a, b,
                               ((s1 + s2 + sz) % 3) == 0);
                     end

      // R6: clear with no saturation, then saturation wins over clear
      run_op(6'h01, 1'b1, 0, 1'b1, '0, '0, 1'b1);
      run_op(6'h01, 1'b1, 0, 1'b1, {16{8'hFF}}, {16{8'h01}}, 1'b1);
      // R9: illegal codes hold result and flag
      run_op(6'h00, 1'b1, 0, 1'b1, '0, {16{8'h01}}, 1'b0);
      run_op(6'h02, 1'b0, 3, 1'b1, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'd1}}, 1'b0);
      run_op(6'h3F, 1'b0, 1, 1'b0, '1, '1, 1'b0);
      run_op(6'h06, 1'b1, 2, 1'b1, '0, '0, 1'b1);
      // R7: tail lanes saturate in narrow mode but the flag stays clear
      run_op(6'h01, 1'b1, 0, 1'b0, {{8{8'hFF}}, 64'd0}, {{8{8'h01}}, 64'd0}, 1'b0);
      // R3: signed 64-bit extremes
      run_op(6'h05, 1'b0, 3, 1'b1, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
             {64'd1, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b1);
      @(negedge clk);
      check(out_valid == 1'b0, "R10 out_valid drops when idle", 128'(out_valid), '0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule